// File: doc/BRIEF.md
# SPI Register-Access Slave With Auto-Increment

This block is the serial front end of a small register bank. An SPI master frames each transaction by holding chip select low. The first byte is a control byte that selects the device and sets the direction. The second byte loads an internal register pointer. Every byte after that is a data byte. On a write, each data byte is sent to the register bank as a one-cycle write strobe on a byte-wide bus. On a read, each byte is fetched from the bank ahead of time and shifted out on the serial output.

A mode input selects how the pointer moves. In sequential mode the pointer steps after every data byte and returns to zero after the last register. In byte mode the pointer stays where the address byte put it. Three strap inputs give the device a bus address, so eight slaves can share one select line. A configuration input decides whether the strap bits take part in device matching.

The serial pins are oversampled by the system clock. The SPI clock must therefore be slow enough that each half period spans several system clocks.

Top module: `spi_regslave`

## Requirements
- R1: While reset is held and directly after it is released, spi_miso_oe, spi_miso, bus_wr_en and bus_rd_en are all 0.
- R2: A control byte is accepted only when its bits [7:4] equal 4'b0100. Bit 0 gives the direction, where 1 means read and 0 means write. When the control byte is rejected, the rest of the frame is ignored: no bus strobe is issued, spi_miso_oe stays low and no register changes.
- R3: When cfg_strap_en is 1, control byte bits [3:1] must also equal cfg_strap_addr for the frame to be accepted. When cfg_strap_en is 0, those bits have no effect.
- R4: In an accepted write frame, each complete data byte produces exactly one bus_wr_en pulse, carrying that byte on bus_wdata and the current pointer on bus_addr. No write and no read strobe are ever raised in the same cycle.
- R5: With cfg_seq_mode = 1, the pointer advances by one after each data byte, and from REG_COUNT-1 it goes to 0. This applies to both reads and writes.
- R6: With cfg_seq_mode = 0, the pointer keeps the value loaded from the address byte for the whole frame. Every data byte then goes to, or comes from, that one register.
- R7: Read data is driven MSB first. Each bit changes after a falling SPI clock edge and is valid at the next rising edge. The byte after the address byte carries the register at the pointer, and each later byte carries the register at the next pointer value.
- R8: spi_miso_oe is 1 only while chip select is low in an accepted read frame, from the end of the address byte until chip select rises. It stays 0 in write frames and in ignored frames.
- R9: A rising edge of chip select ends the frame at once. A partly shifted byte is discarded without a strobe, and the next frame starts again with a control byte.
- R10: bus_rd_en is pulsed one cycle after the address byte of a read frame completes, and again after each read data byte. bus_rdata is sampled in the cycle after bus_rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock, mode 0 |
| spi_cs_n | input | 1 | Chip select, active low; frames a transaction |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Drive enable for the serial output pad |
| cfg_strap_addr | input | 3 | Strap address of this device |
| cfg_strap_en | input | 1 | 1: strap bits must match the control byte |
| cfg_seq_mode | input | 1 | 1: pointer increments with wrap; 0: pointer held |
| bus_addr | output | 8 | Register address for the current access |
| bus_wr_en | output | 1 | One-cycle write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rd_en | output | 1 | One-cycle read strobe |
| bus_rdata | input | 8 | Read data, valid one cycle after bus_rd_en |

## Verification
Two functions can land in the same cycle: loading the prefetched read byte into the output shifter, and shifting on a falling SPI clock edge. A collision would drop a bit at a byte boundary. Multi-byte sequential reads provoke this race, including one that crosses the wrap from the last register to register 0. In each, the load triggered by the eighth rising edge of a byte races the following falling edge. Every received byte is judged against a model of the register contents kept by the bench. A frame that is cut off in the middle of a byte is also judged: the cut-off byte must not produce a strobe, and the registers next to it must read back unchanged.

// File: rtl/spi_regslave_pkg.sv
package spi_regslave_pkg;

  typedef enum logic [2:0] {
    PH_CTRL  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_WDATA = 3'd2,
    PH_RDATA = 3'd3,
    PH_SKIP  = 3'd4
  } phase_e;

  // Device selection: identifier nibble plus optional strap comparison.
  function automatic logic ctrl_accept(input logic [7:0] ctrl,
                                       input logic [3:0] dev_id,
                                       input logic [2:0] strap,
                                       input logic       strap_en);
    return (ctrl[7:4] == dev_id) && (!strap_en || (ctrl[3:1] == strap));
  endfunction

  // Pointer policy: hold in byte mode, step with wrap in sequential mode.
  function automatic logic [7:0] ptr_next(input logic [7:0] ptr,
                                          input logic [7:0] last,
                                          input logic       seq);
    if (!seq) return ptr;
    return (ptr >= last) ? 8'd0 : ptr + 8'd1;
  endfunction

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic mosi_s
);
  // Each stage holds {sclk, cs_n, mosi}.
  logic [2:0] pipe [STAGES];
  logic [2:0] synced;
  logic       sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= 3'b010;
      sclk_d <= 1'b0;
    end else begin
      pipe[0] <= {sclk, cs_n, mosi};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      sclk_d <= pipe[STAGES-1][2];
    end
  end

  assign synced    = pipe[STAGES-1];
  assign sclk_rise = synced[2] & ~sclk_d;
  assign sclk_fall = ~synced[2] & sclk_d;
  assign cs_act    = ~synced[1];
  assign mosi_s    = synced[0];
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_act,
  input  logic       sclk_rise,
  input  logic       sclk_fall,
  input  logic       mosi_s,
  input  logic       tx_load,
  input  logic [7:0] tx_data,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       miso
);
  logic [2:0] bit_cnt;
  logic [6:0] rx_sr;
  logic [7:0] tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= 3'd0;
      rx_sr     <= 7'd0;
      tx_sr     <= 8'd0;
      miso      <= 1'b0;
      byte_done <= 1'b0;
      rx_byte   <= 8'd0;
    end else begin
      byte_done <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= 3'd0;
        rx_sr   <= 7'd0;
        tx_sr   <= 8'd0;
        miso    <= 1'b0;
      end else begin
        if (sclk_rise) begin
          rx_sr   <= {rx_sr[5:0], mosi_s};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_done <= 1'b1;
            rx_byte   <= {rx_sr, mosi_s};
          end
        end
        if (tx_load) begin
          tx_sr <= tx_data;
        end else if (sclk_fall) begin
          miso  <= tx_sr[7];
          tx_sr <= {tx_sr[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_regslave_pkg::*;
#(
  parameter logic [3:0] DEV_ID    = 4'b0100,
  parameter int         REG_COUNT = 22
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_act,
  input  logic       byte_done,
  input  logic [7:0] rx_byte,
  input  logic [2:0] strap_addr,
  input  logic       strap_en,
  input  logic       seq_mode,
  output phase_e     phase,
  output logic [7:0] ptr,
  output logic [7:0] bus_addr,
  output logic       bus_wr_en,
  output logic [7:0] bus_wdata,
  output logic       bus_rd_en,
  output logic       tx_load
);
  localparam logic [7:0] LAST_REG = 8'(REG_COUNT - 1);

  logic       is_read;
  logic [7:0] ptr_step;

  assign ptr_step = ptr_next(ptr, LAST_REG, seq_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_CTRL;
      ptr       <= 8'd0;
      is_read   <= 1'b0;
      bus_addr  <= 8'd0;
      bus_wr_en <= 1'b0;
      bus_wdata <= 8'd0;
      bus_rd_en <= 1'b0;
      tx_load   <= 1'b0;
    end else begin
      bus_wr_en <= 1'b0;
      bus_rd_en <= 1'b0;
      tx_load   <= bus_rd_en;
      if (!cs_act) begin
        phase <= PH_CTRL;
      end else if (byte_done) begin
        unique case (phase)
          PH_CTRL: begin
            is_read <= rx_byte[0];
            phase   <= ctrl_accept(rx_byte, DEV_ID, strap_addr, strap_en)
                       ? PH_ADDR : PH_SKIP;
          end
          PH_ADDR: begin
            ptr      <= rx_byte;
            bus_addr <= rx_byte;
            if (is_read) begin
              bus_rd_en <= 1'b1;
              phase     <= PH_RDATA;
            end else begin
              phase <= PH_WDATA;
            end
          end
          PH_WDATA: begin
            bus_addr  <= ptr;
            bus_wdata <= rx_byte;
            bus_wr_en <= 1'b1;
            ptr       <= ptr_step;
          end
          PH_RDATA: begin
            ptr       <= ptr_step;
            bus_addr  <= ptr_step;
            bus_rd_en <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
  import spi_regslave_pkg::*;
#(
  parameter logic [3:0] DEV_ID      = 4'b0100,
  parameter int         REG_COUNT   = 22,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       spi_miso_oe,
  input  logic [2:0] cfg_strap_addr,
  input  logic       cfg_strap_en,
  input  logic       cfg_seq_mode,
  output logic [7:0] bus_addr,
  output logic       bus_wr_en,
  output logic [7:0] bus_wdata,
  output logic       bus_rd_en,
  input  logic [7:0] bus_rdata
);
  // Internal events, named for the checker.
  logic       sclk_rise;
  logic       sclk_fall;
  logic       cs_act;
  logic       mosi_s;
  logic       byte_done;
  logic [7:0] rx_byte;
  logic       tx_load;
  logic [7:0] ptr;
  phase_e     phase;

  spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (spi_sclk),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_act    (cs_act),
    .mosi_s    (mosi_s)
  );

  spi_byte_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .mosi_s    (mosi_s),
    .tx_load   (tx_load),
    .tx_data   (bus_rdata),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .miso      (spi_miso)
  );

  spi_frame_ctrl #(.DEV_ID(DEV_ID), .REG_COUNT(REG_COUNT)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_act     (cs_act),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .strap_addr (cfg_strap_addr),
    .strap_en   (cfg_strap_en),
    .seq_mode   (cfg_seq_mode),
    .phase      (phase),
    .ptr        (ptr),
    .bus_addr   (bus_addr),
    .bus_wr_en  (bus_wr_en),
    .bus_wdata  (bus_wdata),
    .bus_rd_en  (bus_rd_en),
    .tx_load    (tx_load)
  );

  // Pad driven only inside an accepted read frame.
  assign spi_miso_oe = cs_act && (phase == PH_RDATA);
endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk
  import spi_regslave_pkg::*;
#(
  parameter int REG_COUNT = 22
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_act,
  input logic       byte_done,
  input phase_e     phase,
  input logic [7:0] ptr,
  input logic       seq_mode,
  input logic       bus_wr_en,
  input logic       bus_rd_en,
  input logic       miso_oe
);
  localparam logic [7:0] LAST_REG = 8'(REG_COUNT - 1);

  AST_WR_RD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_en && bus_rd_en)); // R4
  AST_WR_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_en |-> $past(byte_done)); // R4
  AST_RD_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_en |-> $past(byte_done)); // R10
  AST_OE_STARTS_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> $past(byte_done)); // R8
  AST_NO_OE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_en |-> !miso_oe); // R8
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |-> (!bus_wr_en && !bus_rd_en && !miso_oe)); // R2
  AST_BYTE_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && byte_done && !seq_mode && (phase == PH_WDATA || phase == PH_RDATA))
      |=> $stable(ptr)); // R6
  AST_SEQ_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && byte_done && seq_mode && (phase == PH_WDATA) && (ptr == LAST_REG))
      |=> (ptr == 8'd0)); // R5
  AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (phase == PH_CTRL)); // R9
endmodule

bind spi_regslave spi_regslave_chk #(.REG_COUNT(REG_COUNT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_act    (cs_act),
  .byte_done (byte_done),
  .phase     (phase),
  .ptr       (ptr),
  .seq_mode  (cfg_seq_mode),
  .bus_wr_en (bus_wr_en),
  .bus_rd_en (bus_rd_en),
  .miso_oe   (spi_miso_oe)
);

// File: tb/spi_regslave_tb_top.sv
module spi_regslave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 10;   // system clocks per SPI half period
  localparam int REG_COUNT  = 22;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b1;
  logic       mosi = 1'b0;
  logic       miso, miso_oe;
  logic [2:0] strap = 3'b010;
  logic       strap_en = 1'b0;
  logic       seq = 1'b1;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic       bus_wr_en, bus_rd_en;

  int vectors = 0;
  int miscompares = 0;

  logic [7:0]  mem [REG_COUNT];
  logic [7:0]  exp_mem [REG_COUNT];
  logic [7:0]  payload [8];
  logic [15:0] wr_expq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regslave #(.REG_COUNT(REG_COUNT)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .cfg_strap_addr(strap),
    .cfg_strap_en(strap_en), .cfg_seq_mode(seq), .bus_addr(bus_addr),
    .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en),
    .bus_rdata(bus_rdata)
  );

  // Register bank model with one-cycle read latency.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_COUNT; i++) mem[i] <= 8'(i * 7 + 3);
      bus_rdata <= 8'd0;
    end else begin
      if (bus_wr_en && int'(bus_addr) < REG_COUNT) mem[bus_addr] <= bus_wdata;
      bus_rdata <= (int'(bus_addr) < REG_COUNT) ? mem[bus_addr] : 8'hEE;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected writes as the design issues them.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && bus_wr_en) begin
        if (wr_expq.size() == 0)
          check(1'b0, "R4", "unexpected write strobe", {bus_addr, bus_wdata}, 32'h0);
        else begin
          logic [15:0] e;
          e = wr_expq.pop_front();
          check({bus_addr, bus_wdata} == e, "R4", "write addr/data", {bus_addr, bus_wdata}, e);
        end
      end
    end
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] model_next(input logic [7:0] p);
    if (!seq) return p;
    if (int'(p) == REG_COUNT - 1) return 8'd0;
    return p + 8'd1;
  endfunction

  task automatic xfer_byte(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 8'd0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = tx[i];
      wait_clks(HALF);
      sclk = 1'b1;
      rx[i] = miso;
      wait_clks(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic set_payload(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    payload[0] = b0; payload[1] = b1; payload[2] = b2;
  endtask

  // Driver: one framed transaction, predicting writes and read data.
  task automatic frame(input logic [3:0] id, input logic [2:0] hw, input bit rd,
                       input logic [7:0] addr, input int n, input string req);
    logic [7:0] rx, p;
    bit ok;
    ok = (id == 4'b0100) && (!strap_en || hw == strap);
    cs_n = 1'b0;
    wait_clks(HALF);
    xfer_byte({id, hw, rd}, 8, rx);
    xfer_byte(addr, 8, rx);
    p = addr;
    for (int k = 0; k < n; k++) begin
      if (!rd) begin
        if (ok) begin
          wr_expq.push_back({p, payload[k]});
          exp_mem[p] = payload[k];
        end
        xfer_byte(payload[k], 8, rx);
        check(miso_oe == 1'b0, "R8", "oe low in write frame", miso_oe, 0);
      end else begin
        xfer_byte(8'h00, 8, rx);
        check(miso_oe == ok, "R8", "oe in read frame", miso_oe, ok);
        if (ok) check(rx == exp_mem[p], (k == 0) ? "R10" : "R7", req, rx, exp_mem[p]);
      end
      p = model_next(p);
    end
    wait_clks(HALF);
    cs_n = 1'b1;
    wait_clks(4 * HALF);
    check(miso_oe == 1'b0, "R9", "oe low after frame end", miso_oe, 0);
    check(wr_expq.size() == 0, "R4", "all writes seen", wr_expq.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL R9 watchdog expired: actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    for (int i = 0; i < REG_COUNT; i++) exp_mem[i] = 8'(i * 7 + 3);
    wait_clks(3);
    check({miso_oe, miso, bus_wr_en, bus_rd_en} == 4'b0, "R1", "outputs in reset",
          {miso_oe, miso, bus_wr_en, bus_rd_en}, 0);
    rst_n = 1'b1;
    wait_clks(5);
    check({miso_oe, miso, bus_wr_en, bus_rd_en} == 4'b0, "R1", "outputs after reset",
          {miso_oe, miso, bus_wr_en, bus_rd_en}, 0);

    // Sequential write with strap bits ignored, then read back.
    set_payload(8'hA1, 8'hB2, 8'hC3);
    frame(4'b0100, 3'b101, 1'b0, 8'd3, 3, "R3 strap ignored write");
    frame(4'b0100, 3'b000, 1'b1, 8'd3, 3, "R7 sequential read");

    // Wrap from the last register to zero.
    set_payload(8'h11, 8'h22, 8'h33);
    frame(4'b0100, 3'b000, 1'b0, 8'd20, 3, "R5 wrap write");
    frame(4'b0100, 3'b000, 1'b1, 8'd21, 2, "R5 wrap read");

    // Byte mode: pointer held.
    seq = 1'b0;
    set_payload(8'h44, 8'h55, 8'h66);
    frame(4'b0100, 3'b000, 1'b0, 8'd7, 3, "R6 held write");
    frame(4'b0100, 3'b000, 1'b1, 8'd7, 2, "R6 held read");
    seq = 1'b1;

    // Strap matching enabled.
    strap_en = 1'b1;
    set_payload(8'h77, 8'h00, 8'h00);
    frame(4'b0100, 3'b010, 1'b0, 8'd12, 1, "R3 strap match write");
    set_payload(8'h88, 8'h00, 8'h00);
    frame(4'b0100, 3'b011, 1'b0, 8'd12, 1, "R3 strap mismatch write");
    frame(4'b0100, 3'b010, 1'b1, 8'd12, 1, "R3 readback after mismatch");
    frame(4'b0100, 3'b110, 1'b1, 8'd12, 1, "R3 mismatched read");
    strap_en = 1'b0;

    // Wrong identifier nibble.
    set_payload(8'h99, 8'h9A, 8'h00);
    frame(4'b0101, 3'b000, 1'b0, 8'd13, 2, "R2 wrong id write");
    frame(4'b0100, 3'b000, 1'b1, 8'd13, 2, "R2 readback after wrong id");
    frame(4'b0101, 3'b000, 1'b1, 8'd13, 1, "R2 wrong id read");

    // Frame cut off in the middle of the second data byte.
    cs_n = 1'b0;
    wait_clks(HALF);
    xfer_byte(8'h40, 8, rx);
    xfer_byte(8'd9, 8, rx);
    wr_expq.push_back({8'd9, 8'h3C});
    exp_mem[9] = 8'h3C;
    xfer_byte(8'h3C, 8, rx);
    xfer_byte(8'hFF, 5, rx);
    wait_clks(HALF);
    cs_n = 1'b1;
    wait_clks(4 * HALF);
    check(wr_expq.size() == 0, "R9", "full byte written before abort", wr_expq.size(), 0);
    frame(4'b0100, 3'b000, 1'b1, 8'd9, 2, "R9 readback after abort");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule